// File: doc/BRIEF.md
# Pixel Cluster Bounding-Box Centroid Unit

This block takes the word stream of one pixel cluster and emits a single result word that holds the cluster centroid and the cluster extent along both axes. Member pixels arrive as offsets relative to a reference pixel. The reference pixel's absolute position comes last, in the closing word, and that pixel is itself a member of the cluster. The unit tracks the smallest and largest offsets on each axis while the cluster streams in. When the closing word arrives it converts the extremes to absolute pixel indices. One cycle later it turns them into physical positions and produces the result.

Positions are given in fine normalised units. One column unit is 25 µm and one row unit is 5 µm. A row pixel is 50 µm tall, so it spans 10 row units. A column pixel normally spans 16 units (400 µm). The first and last column of every 18-column readout chip is wider and spans 24 units (600 µm). Because of this, the position of a column is a cumulative sum of widths and cannot be a plain multiple of its index. The box is measured between the centres of the outermost pixels. Its midpoint is the centroid.

Top module: `ccu_centroid`

## Requirements
- R1: Each accepted closing word produces exactly one result word. out_valid is high for one cycle, two clock edges after the edge that accepted the closing word. No other cycle asserts out_valid.
- R2: A word with in_last=0 is a hit. The low LOC_W bits of in_col and in_row are its two's-complement offsets from the reference pixel. A word with in_last=1 closes the cluster and carries the reference pixel's absolute column and row. The reference pixel counts as a cluster member at offset (0,0).
- R3: The centre of column c in column units is built as follows. Every column whose index modulo 18 is 0 or 17 is 24 units wide, and every other column is 16 units wide. The centre is the sum of the widths of columns 0..c-1 plus half the width of column c. Examples: column 0 is 12, column 1 is 32, column 17 is 292, column 18 is 316.
- R4: The centre of row r in row units is 10·r + 5.
- R5: out_cen_col is the mean of the centres of the minimum and maximum member columns. out_cen_row is the mean of the centres of the minimum and maximum member rows.
- R6: out_size_col and out_size_row each equal max − min + 1 in pixels, saturating at 2^SIZE_W − 1 (15 by default).
- R7: A cluster consisting only of its closing word yields the centre of that pixel and a size of 1 by 1.
- R8: The order of hits within a cluster does not change the result, and repeated hits have no effect.
- R9: A new cluster may begin on the cycle right after a closing word. Nothing from the previous cluster carries over.
- R10: While rst is high, in_ready and out_valid are 0. in_ready is 1 from the first cycle after reset is released.
- R11: Words presented with in_valid low have no effect on any later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Unit accepts a word on this cycle |
| in_last | input | 1 | 1: closing word with absolute reference; 0: hit with local offsets |
| in_col | input | COL_W | Column field (absolute, or offset in the low LOC_W bits) |
| in_row | input | ROW_W | Row field (absolute, or offset in the low LOC_W bits) |
| out_valid | output | 1 | Result word valid for one cycle |
| out_cen_col | output | COL_W+5 | Centroid column, 25 µm units |
| out_cen_row | output | ROW_W+4 | Centroid row, 5 µm units |
| out_size_col | output | SIZE_W | Cluster width in pixels, saturating |
| out_size_row | output | SIZE_W | Cluster height in pixels, saturating |

## Verification
The hardest cases to reach from the ports are clusters whose bounding box straddles a chip boundary. There the minimum and maximum columns have different physical widths, and an error in the cumulative width sum changes only the centroid. The stimulus places reference pixels next to column 17/18 and uses negative offsets, so that the extremes fall on both sides of the wide columns. Clusters are also sent back to back with no idle cycle, and a span wider than the size field is used to force saturation.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

    // Default geometry of one readout chip along the column axis
    localparam int CCU_CHIP_COLS = 18;
    localparam int CCU_NORM_U    = 16;   // 400 um in 25 um units
    localparam int CCU_EDGE_U    = 24;   // 600 um in 25 um units

    // Row pitch: 50 um in 5 um units
    localparam int CCU_ROW_U     = 10;

    typedef enum logic {
        WORD_HIT = 1'b0,
        WORD_END = 1'b1
    } word_kind_e;

endpackage

// File: rtl/ccu_extent.sv
module ccu_extent #(
    parameter int LOC_W = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd,
    input  logic                    close,
    input  logic signed [LOC_W-1:0] val,
    output logic signed [LOC_W-1:0] fold_min,
    output logic signed [LOC_W-1:0] fold_max
);

    typedef struct packed {
        logic             have;
        logic [LOC_W-1:0] mn;
        logic [LOC_W-1:0] mx;
    } ext_t;

    ext_t ext_d, ext_q;

    always_comb begin
        ext_d    = ext_q;
        fold_min = val;
        fold_max = val;
        if (ext_q.have && ($signed(ext_q.mn) < val)) fold_min = $signed(ext_q.mn);
        if (ext_q.have && ($signed(ext_q.mx) > val)) fold_max = $signed(ext_q.mx);
        if (upd) begin
            if (close) begin
                ext_d.have = 1'b0;
            end else begin
                ext_d.have = 1'b1;
                ext_d.mn   = fold_min;
                ext_d.mx   = fold_max;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ext_q <= '0;
        else     ext_q <= ext_d;
    end

    AST_EXT_ORDER: assert property (@(posedge clk) disable iff (rst)
        ext_q.have |-> ($signed(ext_q.mn) <= $signed(ext_q.mx))); // R6

endmodule

// File: rtl/ccu_colmap.sv
module ccu_colmap #(
    parameter int COL_W     = 9,
    parameter int CU_W      = 14,
    parameter int CHIP_COLS = 18,
    parameter int NORM_U    = 16,
    parameter int EDGE_U    = 24
) (
    input  logic [COL_W-1:0] col,
    output logic [CU_W-1:0]  centre
);

    localparam int CHIP_U = 2 * EDGE_U + (CHIP_COLS - 2) * NORM_U;

    logic [CU_W-1:0] chip_w;
    logic [CU_W-1:0] win_w;
    logic [CU_W-1:0] start_w;
    logic            wide;

    always_comb begin
        chip_w  = CU_W'(col / COL_W'(CHIP_COLS));
        win_w   = CU_W'(col % COL_W'(CHIP_COLS));
        wide    = (win_w == '0) || (win_w == CU_W'(CHIP_COLS - 1));
        start_w = chip_w * CU_W'(CHIP_U);
        if (win_w != '0)
            start_w = start_w + CU_W'(EDGE_U) + (win_w - CU_W'(1)) * CU_W'(NORM_U);
        centre  = start_w + (wide ? CU_W'(EDGE_U / 2) : CU_W'(NORM_U / 2));
    end

endmodule

// File: rtl/ccu_centroid.sv
module ccu_centroid
    import ccu_pkg::*;
#(
    parameter  int COL_W     = 9,
    parameter  int ROW_W     = 9,
    parameter  int LOC_W     = 5,
    parameter  int SIZE_W    = 4,
    parameter  int CHIP_COLS = CCU_CHIP_COLS,
    parameter  int NORM_U    = CCU_NORM_U,
    parameter  int EDGE_U    = CCU_EDGE_U,
    localparam int CU_W      = COL_W + 5,
    localparam int RU_W      = ROW_W + 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_last,
    input  logic [COL_W-1:0]  in_col,
    input  logic [ROW_W-1:0]  in_row,
    output logic              out_valid,
    output logic [CU_W-1:0]   out_cen_col,
    output logic [RU_W-1:0]   out_cen_row,
    output logic [SIZE_W-1:0] out_size_col,
    output logic [SIZE_W-1:0] out_size_row
);

    localparam int SIZE_MAX = (1 << SIZE_W) - 1;
    localparam int SPAN_W   = (COL_W > ROW_W ? COL_W : ROW_W) + 1;

    typedef struct packed {
        logic              rdy;
        logic              v1;
        logic [COL_W-1:0]  cmin;
        logic [COL_W-1:0]  cmax;
        logic [ROW_W-1:0]  rmin;
        logic [ROW_W-1:0]  rmax;
        logic              vo;
        logic [CU_W-1:0]   occ;
        logic [RU_W-1:0]   ocr;
        logic [SIZE_W-1:0] osc;
        logic [SIZE_W-1:0] osr;
    } st_t;

    st_t st_d, st_q;

    logic                    acc;
    logic                    is_end;
    logic signed [LOC_W-1:0] loc_c, loc_r;
    logic signed [LOC_W-1:0] fmin_c, fmax_c, fmin_r, fmax_r;
    logic [CU_W-1:0]         cen_lo, cen_hi;
    logic [SPAN_W-1:0]       span_c, span_r;

    assign acc    = in_valid && st_q.rdy;
    assign is_end = (word_kind_e'(in_last) == WORD_END);
    assign loc_c  = is_end ? '0 : $signed(in_col[LOC_W-1:0]);
    assign loc_r  = is_end ? '0 : $signed(in_row[LOC_W-1:0]);

    ccu_extent #(.LOC_W(LOC_W)) u_ext_col (
        .clk(clk), .rst(rst), .upd(acc), .close(is_end), .val(loc_c),
        .fold_min(fmin_c), .fold_max(fmax_c)
    );

    ccu_extent #(.LOC_W(LOC_W)) u_ext_row (
        .clk(clk), .rst(rst), .upd(acc), .close(is_end), .val(loc_r),
        .fold_min(fmin_r), .fold_max(fmax_r)
    );

    ccu_colmap #(.COL_W(COL_W), .CU_W(CU_W), .CHIP_COLS(CHIP_COLS),
                 .NORM_U(NORM_U), .EDGE_U(EDGE_U)) u_map_lo (
        .col(st_q.cmin), .centre(cen_lo)
    );

    ccu_colmap #(.COL_W(COL_W), .CU_W(CU_W), .CHIP_COLS(CHIP_COLS),
                 .NORM_U(NORM_U), .EDGE_U(EDGE_U)) u_map_hi (
        .col(st_q.cmax), .centre(cen_hi)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rdy = 1'b1;

        // Stage 1: offsets become absolute indices on the closing word
        st_d.v1 = acc && is_end;
        if (acc && is_end) begin
            st_d.cmin = COL_W'($signed({1'b0, in_col}) + (COL_W+1)'(fmin_c));
            st_d.cmax = COL_W'($signed({1'b0, in_col}) + (COL_W+1)'(fmax_c));
            st_d.rmin = ROW_W'($signed({1'b0, in_row}) + (ROW_W+1)'(fmin_r));
            st_d.rmax = ROW_W'($signed({1'b0, in_row}) + (ROW_W+1)'(fmax_r));
        end

        // Stage 2: physical centres, midpoint and extent
        span_c  = SPAN_W'(st_q.cmax) - SPAN_W'(st_q.cmin) + SPAN_W'(1);
        span_r  = SPAN_W'(st_q.rmax) - SPAN_W'(st_q.rmin) + SPAN_W'(1);
        st_d.vo = st_q.v1;
        if (st_q.v1) begin
            st_d.occ = CU_W'(({1'b0, cen_lo} + {1'b0, cen_hi}) >> 1);
            // (10a+5 + 10b+5)/2 = 5(a+b) + 5
            st_d.ocr = RU_W'(CCU_ROW_U / 2) * (RU_W'(st_q.rmin) + RU_W'(st_q.rmax))
                     + RU_W'(CCU_ROW_U / 2);
            st_d.osc = (span_c > SPAN_W'(SIZE_MAX)) ? SIZE_W'(SIZE_MAX) : SIZE_W'(span_c);
            st_d.osr = (span_r > SPAN_W'(SIZE_MAX)) ? SIZE_W'(SIZE_MAX) : SIZE_W'(span_r);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign in_ready     = st_q.rdy;
    assign out_valid    = st_q.vo;
    assign out_cen_col  = st_q.occ;
    assign out_cen_row  = st_q.ocr;
    assign out_size_col = st_q.osc;
    assign out_size_row = st_q.osr;

    AST_ONE_WORD: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && in_ready && in_last, 2)); // R1

    AST_SIZE_MIN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_size_col != '0 && out_size_row != '0)); // R6

    AST_CEN_ORDER: assert property (@(posedge clk) disable iff (rst)
        st_q.v1 |-> (cen_hi >= cen_lo)); // R3

    AST_READY_UP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> in_ready); // R10

endmodule

// File: tb/sim_ccu_centroid.sv
module sim_ccu_centroid;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_last = 1'b0;
    logic [8:0]  in_col = '0;
    logic [8:0]  in_row = '0;
    logic        out_valid;
    logic [13:0] out_cen_col;
    logic [12:0] out_cen_row;
    logic [3:0]  out_size_col;
    logic [3:0]  out_size_row;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ccu_centroid u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_last(in_last), .in_col(in_col), .in_row(in_row),
        .out_valid(out_valid), .out_cen_col(out_cen_col), .out_cen_row(out_cen_row),
        .out_size_col(out_size_col), .out_size_row(out_size_row)
    );

    typedef struct packed {
        logic [8:0]  rc;
        logic [8:0]  rr;
        logic [1:0]  nh;
        logic [4:0]  h0c;
        logic [4:0]  h0r;
        logic [4:0]  h1c;
        logic [4:0]  h1r;
        logic [13:0] ecc;
        logic [12:0] ecr;
        logic [3:0]  esc;
        logic [3:0]  esr;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{9'd1,  9'd3,  2'd0, 5'd0,     5'd0,     5'd0,     5'd0,     14'd32,  13'd35,  4'd1, 4'd1},
        '{9'd2,  9'd4,  2'd2, 5'd1,     5'd0,     5'd0,     5'd1,     14'd56,  13'd50,  4'd2, 4'd2},
        '{9'd17, 9'd10, 2'd2, 5'd1,     5'd0,     5'd2,     5'b11111, 14'd314, 13'd100, 4'd3, 4'd2},
        '{9'd0,  9'd0,  2'd2, 5'd1,     5'd2,     5'd1,     5'd2,     14'd22,  13'd15,  4'd2, 4'd3},
        '{9'd20, 9'd20, 2'd2, 5'b11101, 5'b11100, 5'b11111, 5'd2,     14'd322, 13'd195, 4'd4, 4'd7}
    };

    logic [13:0] got_cc [16];
    logic [12:0] got_cr [16];
    logic [3:0]  got_sc [16];
    logic [3:0]  got_sr [16];
    int n_got = 0;

    always @(negedge clk) begin
        if (!rst && out_valid && n_got < 16) begin
            got_cc[n_got] <= out_cen_col;
            got_cr[n_got] <= out_cen_row;
            got_sc[n_got] <= out_size_col;
            got_sr[n_got] <= out_size_row;
            n_got <= n_got + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic word(input logic last, input logic [8:0] c, input logic [8:0] r);
        in_valid = 1'b1;
        in_last  = last;
        in_col   = c;
        in_row   = r;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk_out(input int idx, input string req, input logic [13:0] cc,
                           input logic [12:0] cr, input logic [3:0] sc, input logic [3:0] sr);
        chk({req, " centroid col"}, 32'(got_cc[idx]), 32'(cc));
        chk({req, " centroid row"}, 32'(got_cr[idx]), 32'(cr));
        chk({req, " size col"},     32'(got_sc[idx]), 32'(sc));
        chk({req, " size row"},     32'(got_sr[idx]), 32'(sr));
    endtask

    initial begin
        int base;
        idle(3);
        chk("R10 ready in reset", 32'(in_ready), 32'd0);
        chk("R10 valid in reset", 32'(out_valid), 32'd0);
        rst = 1'b0;
        idle(2);
        chk("R10 ready after reset", 32'(in_ready), 32'd1);

        // Table: clusters back to back, no idle cycle between them (R9, R2, R8)
        for (int i = 0; i < NV; i++) begin
            for (int h = 0; h < int'(VEC[i].nh); h++) begin
                if (h == 0) word(1'b0, {4'b0, VEC[i].h0c}, {4'b0, VEC[i].h0r});
                else        word(1'b0, {4'b0, VEC[i].h1c}, {4'b0, VEC[i].h1r});
            end
            word(1'b1, VEC[i].rc, VEC[i].rr);
        end
        idle(4);
        chk("R1 result count table", 32'(n_got), 32'(NV));
        for (int i = 0; i < NV; i++)
            chk_out(i, "R3 R4 R5 R9 table", VEC[i].ecc, VEC[i].ecr, VEC[i].esc, VEC[i].esr);

        // R7: lone wide edge pixel
        base = n_got;
        word(1'b1, 9'd17, 9'd0);
        idle(3);
        chk("R1 single word", 32'(n_got), 32'(base + 1));
        chk_out(base, "R7 single", 14'd292, 13'd5, 4'd1, 4'd1);

        // R6: column span 31 saturates
        base = n_got;
        word(1'b0, {4'b0, 5'b10001}, 9'd0);
        word(1'b0, {4'b0, 5'd15}, 9'd0);
        word(1'b1, 9'd100, 9'd100);
        idle(3);
        chk_out(base, "R6 saturate", 14'd1696, 13'd1005, 4'd15, 4'd1);

        // R11: words with in_valid low are ignored
        base = n_got;
        in_valid = 1'b0; in_last = 1'b1; in_col = 9'd15; in_row = 9'd15;
        idle(3);
        chk("R11 no output from idle words", 32'(n_got), 32'(base));
        word(1'b0, 9'd1, 9'd0);
        in_last = 1'b0; in_col = 9'd15; in_row = 9'd14;
        idle(2);
        word(1'b1, 9'd18, 9'd1);
        idle(3);
        chk("R11 one result", 32'(n_got), 32'(base + 1));
        chk_out(base, "R11 ignored", 14'd326, 13'd15, 4'd2, 4'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 20000; k++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule